// File: doc/BRIEF.md
# Four-Channel PWM Timer

This block is a timer with four independent 16-bit counting channels, each driving one output pin. Every channel divides the system clock by a selectable ratio, counts on the rising, falling or both edges of the divided clock, and compares its counter against four general registers. One general register can be chosen to send the counter back to zero, which fixes the period. General register A acts as the compare point that changes the pin.

Software programs the unit through a simple register bus with byte offsets and 16-bit data. A single shared run register holds one enable bit per channel. Each channel has its own window of registers: control, mode, pin control, interrupt enable, status, counter and general registers A to D. In PWM mode the pin goes back to its programmed initial level whenever the counter clears. A match on A applies a pin action, so A sets the duty point and the clearing register sets the period. Buffer-enable bits in the mode register are stored but have no effect.

Top module: `pwm_timer_unit`

## Requirements
- R1: After reset every register reads 0, all run bits are 0 and every pin is low.
- R2: Channel n's window starts at 0x10 + n*0x40, with control 0x00, mode 0x04, pin control 0x08, interrupt enable 0x0C, status 0x10, counter 0x14 and general A/B/C/D at 0x18/0x1C/0x20/0x24. Control and interrupt enable keep bits [7:0], mode keeps bits [6:4] and [1:0], pin control keeps bits [2:0], and general registers keep all 16 bits.
- R3: The run register at offset 0x00 has bit n for channel n. A write replaces all bits. A channel whose bit is clear holds its counter, and the other channels' bits are unaffected when software rewrites one bit.
- R4: Control bits [2:0] select the division: 0 divides by 1, 1 by 4, 2 by 16, 3 by 64, and other codes divide by 1. On rising-edge counting the counter advances once every N clocks.
- R5: Control bits [4:3] select the counting edge: 0 rising, 1 falling (same rate, half a divided period later), 2 both edges (one advance every N/2 clocks, or every clock when N is 1).
- R6: Control bits [7:5] select the clear source: 1 is A, 2 is B, 5 is C, 6 is D, and any other code means no clear. The counter steps from the selected register's value to 0. Without a clear it wraps from 0xFFFF to 0.
- R7: In PWM mode (mode bits [1:0] = 2), with clear on B and pin code 3'b101, the pin is high for A*N clocks out of a period of (B+1)*N clocks.
- R8: With pin code 3'b010 under the same settings, the pin is high for (B-A+1)*N clocks out of (B+1)*N clocks.
- R9: A write to pin control drives the pin to its bit 2 on the clock edge of the write.
- R10: Pin control bits [1:0] give the action when the counter reaches A: 0 keep, 1 low, 2 high, 3 toggle. Outside PWM mode a clear does not restore the initial level.
- R11: Status bit 0 sets when the counter reaches A, and bit 1 sets when it reaches B. Both bits stay set until software overwrites the status register.
- R12: A counter write loads the value on the next clock edge. A general register written while running takes effect at once, whatever the buffer bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Write strobe for the register bus |
| regAddr | input | 8 | Byte offset of the register |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, combinational from regAddr |
| pwmOut | output | 4 | One output pin per channel |

## Verification
Register writes take effect at the first rising edge after the bench raises the strobe. Run bits, counters, general registers and the pin after a pin-control write are therefore read back at the falling edge that follows, one cycle after the write. Reads are combinational, so the bench samples them shortly after it drives the address. Waveform checks skip the partial first period: the bench waits for a low-to-high transition caused by a counter clear, then counts the high and low clocks at each falling edge. The counter moves one divided tick after its run bit rises, so these counts equal A*N and (B+1)*N exactly.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int REG_W = 16;
  localparam int NUM_GR = 4;

  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_MODE = 6'h04;
  localparam logic [5:0] OFS_PINC = 6'h08;
  localparam logic [5:0] OFS_IEN  = 6'h0C;
  localparam logic [5:0] OFS_STAT = 6'h10;
  localparam logic [5:0] OFS_CNT  = 6'h14;
  localparam logic [5:0] OFS_GRA  = 6'h18;
  localparam logic [5:0] OFS_GRB  = 6'h1C;
  localparam logic [5:0] OFS_GRC  = 6'h20;
  localparam logic [5:0] OFS_GRD  = 6'h24;

  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;
  localparam logic [1:0] EDGE_BOTH = 2'd2;

  localparam logic [1:0] MODE_PWM = 2'd2;

  typedef struct packed {
    logic              run;
    logic              wrCtrl;
    logic              wrMode;
    logic              wrPinc;
    logic              wrIen;
    logic              wrStat;
    logic              wrCnt;
    logic [NUM_GR-1:0] wrGr;
  } chanStrobe_t;

  typedef struct packed {
    logic [7:0]                   ctrl;
    logic [6:0]                   mode;
    logic [2:0]                   pinc;
    logic [7:0]                   ien;
    logic [1:0]                   stat;
    logic [REG_W-1:0]             cnt;
    logic [NUM_GR-1:0][REG_W-1:0] gr;
  } chanView_t;

  // Last value of the divider counter for each prescale code.
  function automatic logic [5:0] divLimit(input logic [2:0] code);
    case (code)
      3'd1:    divLimit = 6'd3;
      3'd2:    divLimit = 6'd15;
      3'd3:    divLimit = 6'd63;
      default: divLimit = 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  chanView_t         chanViews [NUM_CH],
  output chanStrobe_t       strobes   [NUM_CH],
  output logic [REG_W-1:0]  regRdata
);

  localparam int CH_BASE = 'h10;
  localparam int STRIDE_LOG = 6;
  localparam int IDX_W = ADDR_W - STRIDE_LOG;

  logic [NUM_CH-1:0] runBits;
  logic [ADDR_W-1:0] relAddr;
  logic [IDX_W-1:0]  chIdx;
  logic [5:0]        ofs;
  logic              inChan;
  logic              runWr;

  assign relAddr = regAddr - ADDR_W'(CH_BASE);
  assign chIdx   = relAddr[ADDR_W-1:STRIDE_LOG];
  assign ofs     = relAddr[STRIDE_LOG-1:0];
  assign inChan  = (regAddr >= ADDR_W'(CH_BASE)) && (int'(chIdx) < NUM_CH);
  assign runWr   = regWe && (regAddr == '0);

  always_ff @(posedge clk) begin
    if (!rstN) runBits <= '0;
    else if (runWr) runBits <= regWdata[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gStrobe
    logic hit;
    assign hit = regWe && inChan && (chIdx == IDX_W'(g));
    always_comb begin
      strobes[g].run    = runBits[g];
      strobes[g].wrCtrl = hit && (ofs == OFS_CTRL);
      strobes[g].wrMode = hit && (ofs == OFS_MODE);
      strobes[g].wrPinc = hit && (ofs == OFS_PINC);
      strobes[g].wrIen  = hit && (ofs == OFS_IEN);
      strobes[g].wrStat = hit && (ofs == OFS_STAT);
      strobes[g].wrCnt  = hit && (ofs == OFS_CNT);
      strobes[g].wrGr   = {hit && (ofs == OFS_GRD), hit && (ofs == OFS_GRC),
                           hit && (ofs == OFS_GRB), hit && (ofs == OFS_GRA)};
    end
  end

  chanView_t selView;

  always_comb begin
    selView = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (chIdx == IDX_W'(c)) selView = chanViews[c];
    regRdata = '0;
    if (regAddr == '0) begin
      regRdata[NUM_CH-1:0] = runBits;
    end else if (inChan) begin
      case (ofs)
        OFS_CTRL: regRdata = REG_W'(selView.ctrl);
        OFS_MODE: regRdata = REG_W'(selView.mode);
        OFS_PINC: regRdata = REG_W'(selView.pinc);
        OFS_IEN:  regRdata = REG_W'(selView.ien);
        OFS_STAT: regRdata = REG_W'(selView.stat);
        OFS_CNT:  regRdata = selView.cnt;
        OFS_GRA:  regRdata = selView.gr[0];
        OFS_GRB:  regRdata = selView.gr[1];
        OFS_GRC:  regRdata = selView.gr[2];
        OFS_GRD:  regRdata = selView.gr[3];
        default:  regRdata = '0;
      endcase
    end
  end

  // R3: a run-register write replaces every bit
  assert_run_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    runWr |=> runBits == $past(regWdata[NUM_CH-1:0]));

  // R3: without a write the run bits keep their value
  assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runWr |=> $stable(runBits));

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      strb,
  input  logic [REG_W-1:0] wdata,
  output chanView_t        view,
  output logic             pinOut
);

  logic [7:0]                   ctrlR;
  logic [6:0]                   modeR;
  logic [2:0]                   pincR;
  logic [7:0]                   ienR;
  logic [1:0]                   statR;
  logic [REG_W-1:0]             cnt;
  logic [NUM_GR-1:0][REG_W-1:0] gr;
  logic [5:0]                   psCnt;

  // Prescaler and edge selection
  logic [5:0] divMax;
  logic       riseTick, fallTick, tick;

  assign divMax   = divLimit(ctrlR[2:0]);
  assign riseTick = strb.run && (psCnt == divMax);
  assign fallTick = strb.run && (psCnt == (divMax >> 1));

  always_comb begin
    case (ctrlR[4:3])
      EDGE_FALL: tick = fallTick;
      EDGE_BOTH: tick = riseTick || fallTick;
      default:   tick = riseTick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.run) psCnt <= '0;
    else if (psCnt == divMax) psCnt <= '0;
    else psCnt <= psCnt + 6'd1;
  end

  // Clear source and next count
  logic             clrEn, clrHit, hitA, hitB;
  logic [REG_W-1:0] clrVal, nextCnt;

  always_comb begin
    clrEn  = 1'b1;
    clrVal = gr[0];
    case (ctrlR[7:5])
      3'd1:    clrVal = gr[0];
      3'd2:    clrVal = gr[1];
      3'd5:    clrVal = gr[2];
      3'd6:    clrVal = gr[3];
      default: clrEn = 1'b0;
    endcase
  end

  assign clrHit  = clrEn && (cnt == clrVal);
  assign nextCnt = clrHit ? '0 : cnt + 1'b1;
  assign hitA    = nextCnt == gr[0];
  assign hitB    = nextCnt == gr[1];

  // Pin level on a count tick
  logic pinNext;

  always_comb begin
    pinNext = pinOut;
    if ((modeR[1:0] == MODE_PWM) && clrHit) pinNext = pincR[2];
    if (hitA) begin
      case (pincR[1:0])
        2'd1:    pinNext = 1'b0;
        2'd2:    pinNext = 1'b1;
        2'd3:    pinNext = ~pinNext;
        default: pinNext = pinNext;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlR  <= '0;
      modeR  <= '0;
      pincR  <= '0;
      ienR   <= '0;
      statR  <= '0;
      cnt    <= '0;
      gr     <= '0;
      pinOut <= 1'b0;
    end else begin
      if (strb.wrCtrl) ctrlR <= wdata[7:0];
      if (strb.wrMode) modeR <= wdata[6:0] & 7'h73;
      if (strb.wrIen)  ienR  <= wdata[7:0];
      if (strb.wrPinc) pincR <= wdata[2:0];
      for (int i = 0; i < NUM_GR; i++)
        if (strb.wrGr[i]) gr[i] <= wdata;
      if (strb.wrCnt) cnt <= wdata;
      else if (tick)  cnt <= nextCnt;
      if (strb.wrPinc) pinOut <= wdata[2];
      else if (tick)   pinOut <= pinNext;
      statR <= (strb.wrStat ? wdata[1:0] : statR) | (tick ? {hitB, hitA} : 2'b00);
    end
  end

  assign view = '{ctrl: ctrlR, mode: modeR, pinc: pincR, ien: ienR,
                  stat: statR, cnt: cnt, gr: gr};

  // R3: a stopped channel keeps its counter
  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.wrCnt) |=> $stable(cnt));

  // R6: reaching the clear source returns the counter to zero
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && clrHit && !strb.wrCnt) |=> cnt == '0);

  // R9: a pin-control write sets the pin to its initial level at once
  assert_pin_init_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPinc |=> pinOut == $past(wdata[2]));

  // R11: status flags are sticky until software writes them
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (statR[0] && !strb.wrStat) |=> statR[0]);

endmodule

// File: rtl/pwm_timer_unit.sv
module pwm_timer_unit
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [NUM_CH-1:0] pwmOut
);

  chanStrobe_t strobes   [NUM_CH];
  chanView_t   chanViews [NUM_CH];

  pwm_timer_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .chanViews(chanViews),
    .strobes  (strobes),
    .regRdata (regRdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    pwm_timer_chan uChan (
      .clk   (clk),
      .rstN  (rstN),
      .strb  (strobes[g]),
      .wdata (regWdata),
      .view  (chanViews[g]),
      .pinOut(pwmOut[g])
    );
  end

endmodule

// File: tb/pwm_timer_unit_test.sv
module pwm_timer_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [3:0]  pwmOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwm_timer_unit uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pwmOut(pwmOut)
  );

  function automatic logic [7:0] chAddr(input int ch, input int ofs);
    return 8'(8'h10 + ch * 8'h40 + ofs);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1'b0;
    #1 d = regRdata;
  endtask

  task automatic setRun(input int ch, input bit on);
    logic [15:0] v;
    busRead(8'h00, v);
    v[ch] = on;
    busWrite(8'h00, v);
  endtask

  task automatic setupPwm(input int ch, input int div, input int edgeSel,
                          input int a, input int b, input bit inv);
    setRun(ch, 0);
    busWrite(chAddr(ch, 'h00), 16'((2 << 5) | (edgeSel << 3) | div));
    busWrite(chAddr(ch, 'h04), 16'h0002);
    busWrite(chAddr(ch, 'h14), 16'h0000);
    busWrite(chAddr(ch, 'h18), 16'(a));
    busWrite(chAddr(ch, 'h1C), 16'(b));
    busWrite(chAddr(ch, 'h08), inv ? 16'h0002 : 16'h0005);
    setRun(ch, 1);
  endtask

  // Counts high and low clocks of one steady-state period, starting at a rise.
  task automatic measure(input int ch, output int hi, output int per);
    int guard = 0;
    hi = 0; per = 0;
    @(negedge clk);
    while (pwmOut[ch] !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    while (pwmOut[ch] !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    while (pwmOut[ch] === 1'b1 && guard < 20000) begin hi++; @(negedge clk); guard++; end
    per = hi;
    while (pwmOut[ch] === 1'b0 && guard < 20000) begin per++; @(negedge clk); guard++; end
  endtask

  task automatic testReset();
    logic [15:0] v;
    busRead(8'h00, v);             check("R1 run reg", v, 0);
    busRead(chAddr(0, 'h00), v);   check("R1 ctrl ch0", v, 0);
    busRead(chAddr(3, 'h14), v);   check("R1 cnt ch3", v, 0);
    busRead(chAddr(2, 'h20), v);   check("R1 grC ch2", v, 0);
    check("R1 pins", pwmOut, 0);
  endtask

  task automatic testReadback();
    logic [15:0] v;
    busWrite(chAddr(2, 'h20), 16'hBEEF); busRead(chAddr(2, 'h20), v); check("R2 grC ch2", v, 'hBEEF);
    busWrite(chAddr(1, 'h24), 16'h1357); busRead(chAddr(1, 'h24), v); check("R2 grD ch1", v, 'h1357);
    busWrite(chAddr(3, 'h00), 16'hFFFF); busRead(chAddr(3, 'h00), v); check("R2 ctrl mask", v, 'h00FF);
    busWrite(chAddr(0, 'h04), 16'hFFFF); busRead(chAddr(0, 'h04), v); check("R2 mode mask", v, 'h0073);
    busWrite(chAddr(1, 'h08), 16'hFFFF); busRead(chAddr(1, 'h08), v); check("R2 pinc mask", v, 'h0007);
    busWrite(chAddr(1, 'h0C), 16'h01FF); busRead(chAddr(1, 'h0C), v); check("R2 ien mask", v, 'h00FF);
    busWrite(chAddr(1, 'h08), 16'h0000);
    busWrite(chAddr(3, 'h00), 16'h0000);
    busWrite(chAddr(0, 'h04), 16'h0000);
  endtask

  task automatic testPwm();
    int hi, per;
    logic [15:0] v;
    setupPwm(0, 0, 0, 3, 9, 0);
    measure(0, hi, per); check("R7 hi div1", hi, 3); check("R7 per div1", per, 10);
    setupPwm(1, 1, 0, 5, 7, 0);
    busRead(8'h00, v); check("R3 run bits after ch1", v, 'h3);
    measure(1, hi, per); check("R4 hi div4", hi, 20); check("R4 per div4", per, 32);
    setupPwm(2, 0, 0, 2, 5, 1);
    measure(2, hi, per); check("R8 hi inverted", hi, 4); check("R8 per inverted", per, 6);
    setupPwm(3, 2, 0, 1, 3, 0);
    busRead(8'h00, v); check("R3 run bits all", v, 'hF);
    measure(3, hi, per); check("R4 hi div16", hi, 16); check("R4 per div16", per, 64);
    measure(0, hi, per); check("R3 ch0 undisturbed", per, 10);
  endtask

  task automatic testEdges();
    int hi, per;
    setupPwm(1, 1, 1, 5, 7, 0);
    measure(1, hi, per); check("R5 falling hi", hi, 20); check("R5 falling per", per, 32);
    setupPwm(1, 1, 2, 5, 7, 0);
    measure(1, hi, per); check("R5 both hi", hi, 10); check("R5 both per", per, 16);
    setupPwm(1, 0, 2, 3, 9, 0);
    measure(1, hi, per); check("R5 both div1 per", per, 10);
  endtask

  task automatic testStop();
    logic [15:0] v0, v1;
    setRun(3, 0);
    busRead(chAddr(3, 'h14), v0);
    repeat (40) @(negedge clk);
    busRead(chAddr(3, 'h14), v1);
    check("R3 stopped counter holds", v1, v0);
    busRead(8'h00, v0); check("R3 other run bits kept", v0, 'h7);
  endtask

  task automatic testClearSources();
    int hi, per;
    logic [15:0] v;
    busWrite(chAddr(3, 'h00), 16'(5 << 5));
    busWrite(chAddr(3, 'h04), 16'h0000);
    busWrite(chAddr(3, 'h14), 16'h0000);
    busWrite(chAddr(3, 'h18), 16'd4);
    busWrite(chAddr(3, 'h20), 16'd4);
    busWrite(chAddr(3, 'h08), 16'h0003);
    setRun(3, 1);
    measure(3, hi, per); check("R6 clear on C toggle hi", hi, 5); check("R10 toggle per", per, 10);
    setRun(3, 0);
    busWrite(chAddr(3, 'h00), 16'(6 << 5));
    busWrite(chAddr(3, 'h18), 16'd7);
    busWrite(chAddr(3, 'h24), 16'd7);
    setRun(3, 1);
    measure(3, hi, per); check("R6 clear on D per", per, 16);
    setRun(3, 0);
    busWrite(chAddr(3, 'h00), 16'h0000);
    busWrite(chAddr(3, 'h18), 16'd100);
    busWrite(chAddr(3, 'h14), 16'hFFFE);
    setRun(3, 1);
    repeat (4) @(negedge clk);
    setRun(3, 0);
    busRead(chAddr(3, 'h14), v);
    check("R6 no clear wraps", int'(v < 16'h0010 && v != 16'h0000), 1);
  endtask

  task automatic testActions();
    int highs;
    setRun(3, 0);
    busWrite(chAddr(3, 'h00), 16'(2 << 5));
    busWrite(chAddr(3, 'h04), 16'h0000);
    busWrite(chAddr(3, 'h14), 16'h0000);
    busWrite(chAddr(3, 'h18), 16'd2);
    busWrite(chAddr(3, 'h1C), 16'd5);
    busWrite(chAddr(3, 'h08), 16'h0005);
    setRun(3, 1);
    repeat (30) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwmOut[3]) highs++; end
    check("R10 drive-low no restore", highs, 0);
    setRun(3, 0);
    busWrite(chAddr(3, 'h08), 16'h0002);
    setRun(3, 1);
    repeat (30) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwmOut[3]) highs++; end
    check("R10 drive-high holds", highs, 20);
    setRun(3, 0);
  endtask

  task automatic testPinInit();
    busWrite(chAddr(3, 'h08), 16'h0004);
    check("R9 init high", pwmOut[3], 1);
    busWrite(chAddr(3, 'h08), 16'h0000);
    check("R9 init low", pwmOut[3], 0);
  endtask

  task automatic testStatusAndLoad();
    logic [15:0] v;
    int hi, per;
    busRead(chAddr(2, 'h10), v); check("R11 flags set", v, 3);
    setRun(2, 0);
    busWrite(chAddr(2, 'h10), 16'h0000);
    busRead(chAddr(2, 'h10), v); check("R11 flags cleared", v, 0);
    busWrite(chAddr(2, 'h14), 16'h1234);
    busRead(chAddr(2, 'h14), v); check("R12 counter load", v, 'h1234);
    busWrite(chAddr(0, 'h04), 16'h0072);
    busWrite(chAddr(0, 'h18), 16'd6);
    measure(0, hi, per); check("R12 duty update hi", hi, 6); check("R12 duty update per", per, 10);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadback();
    testPwm();
    testEdges();
    testStop();
    testClearSources();
    testActions();
    testPinInit();
    testStatusAndLoad();
    finishRun();
  end

endmodule